// File: doc/BRIEF.md
# Non-posted completion tracker

This block keeps a small table of outbound non-posted requests that still wait for completions. The issuer picks a free tag and names how many link-level pieces the request was split into. From then on the tag's entry counts its outstanding pieces, gathers any error seen on their completions, and runs its own timeout counter. The counter is loaded from a programmable timeout value at issue and again after every piece that completes.

Each inbound completion carries a tag, a two-bit status code and two error flags. The block classifies it as successful, unsupported request, completer abort, poisoned or ECRC-damaged. A completion whose tag names no live entry counts as unexpected, and this covers a completion that arrives after its entry was already freed by a timeout. Errors on a split request are held inside the entry. They reach the status registers only when the entry's last piece resolves, either through a completion or through expiry. Two sticky registers record the results: a 32-bit uncorrectable-status register and a 3-bit local error-detect register. Software clears their bits by writing ones. An interrupt output rises while any set bit has its enable bit set.

Each entry runs a two-state machine. In FREE it waits for an issue; the transition ISSUE moves it to PENDING. In PENDING it leaves through LAST_PIECE, when the completion of its final piece arrives, or through EXPIRE, when its counter is at zero and no completion arrives that cycle. Both transitions commit the gathered errors and return the entry to FREE. The transition PIECE, a non-final completion, keeps the entry in PENDING and reloads its timer.

Top module: `npt_tracker`

## Requirements
- R1: An entry in PENDING that sees no completion for cfg_timeout+1 consecutive clock edges after its issue or its last completed piece is freed on that edge. The same edge sets det_status bit 0 (timeout), along with any errors the entry had gathered.
- R2: A completion whose tag is not busy sets unc_status bit 16 (unexpected) on the following edge. This includes a completion that arrives after its entry timed out. Such a completion sets no other bit.
- R3: Status code 1 (unsupported request) and the reserved code 3 set unc_status bit 20 and det_status bit 1 (not successful).
- R4: Status code 2 (completer abort) sets unc_status bit 15 and det_status bits 1 and 2. Code 0 is success.
- R5: A completion with cpl_poisoned high sets unc_status bit 12.
- R6: A completion with cpl_ecrc_err high sets unc_status bit 19.
- R7: The errors of a request split into N pieces reach the status registers only on the edge where its last piece resolves, by completion or by expiry. Before that edge no bit for them is visible.
- R8: An issue with req_pieces of 1 or more to a tag that is not busy makes tag_busy for that tag high after the edge. An issue to a busy tag, or an issue with req_pieces of 0, is ignored.
- R9: irq is high exactly when some bit is set in both unc_status and unc_en, or in both det_status and det_en.
- R10: Status bits stay set until a 1 is written to the same bit of unc_clr or det_clr. When a set and a clear of the same bit fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Issue a non-posted request this cycle |
| req_tag | input | 3 | Tag of the issued request |
| req_pieces | input | 4 | Number of link pieces in the request |
| cpl_valid | input | 1 | A completion arrives this cycle |
| cpl_tag | input | 3 | Tag carried by the completion |
| cpl_status | input | 2 | Completion status: 0 ok, 1 unsupported, 2 abort, 3 reserved |
| cpl_poisoned | input | 1 | Completion carries poisoned data |
| cpl_ecrc_err | input | 1 | Completion failed its end-to-end CRC |
| cfg_timeout | input | 16 | Timeout count loaded into entry timers |
| unc_en | input | 32 | Interrupt enables for unc_status |
| det_en | input | 3 | Interrupt enables for det_status |
| unc_clr | input | 32 | Write-one-to-clear strobes for unc_status |
| det_clr | input | 3 | Write-one-to-clear strobes for det_status |
| unc_status | output | 32 | Sticky uncorrectable-status register |
| det_status | output | 3 | Sticky local error-detect register (0 timeout, 1 not successful, 2 abort) |
| tag_busy | output | 8 | One bit per tag, high while the entry is PENDING |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that every input has a known value once reset is released. They also assume that cpl_tag and req_tag index one of the eight entries, and that clear strobes may overlap new errors in any cycle. The stimulus keeps to these limits. It drives all inputs just after the falling edge, keeps tags within the table, and uses small timeout values so that expiry, late completions and split groups that straddle an expiry all occur within the run. A random phase then overlaps issues, completions to live and dead tags, clears and enable changes in the same cycles.

// File: rtl/npt_pkg.sv
package npt_pkg;
    localparam int UNC_W = 32;
    localparam int DET_W = 3;
    localparam int ERR_W = 5;

    // internal error-mask bit positions
    localparam int EB_UR   = 0;
    localparam int EB_CA   = 1;
    localparam int EB_EP   = 2;
    localparam int EB_ECRC = 3;
    localparam int EB_TO   = 4;

    // uncorrectable-status bit positions
    localparam int UNC_EP    = 12;
    localparam int UNC_CA    = 15;
    localparam int UNC_UNEXP = 16;
    localparam int UNC_ECRC  = 19;
    localparam int UNC_UR    = 20;

    // local error-detect bit positions
    localparam int DET_TO = 0;
    localparam int DET_NS = 1;
    localparam int DET_CA = 2;

    typedef logic [ERR_W-1:0] err_mask_t;

    typedef enum logic [1:0] {
        CS_OK  = 2'd0,
        CS_UR  = 2'd1,
        CS_CA  = 2'd2,
        CS_RSV = 2'd3
    } cpl_status_e;

    typedef enum logic {
        ES_FREE    = 1'b0,
        ES_PENDING = 1'b1
    } entry_state_e;
endpackage

// File: rtl/npt_classify.sv
module npt_classify
    import npt_pkg::*;
(
    input  logic [1:0] status,
    input  logic       poisoned,
    input  logic       ecrc_err,
    output err_mask_t  err
);
    always_comb begin
        err = '0;
        unique case (cpl_status_e'(status))
            CS_OK:         ;
            CS_UR, CS_RSV: err[EB_UR] = 1'b1;
            CS_CA:         err[EB_CA] = 1'b1;
        endcase
        err[EB_EP]   = poisoned;
        err[EB_ECRC] = ecrc_err;
    end
endmodule

// File: rtl/npt_entry.sv
module npt_entry
    import npt_pkg::*;
#(
    parameter int PIECE_W = 4,
    parameter int TMR_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [PIECE_W-1:0] issue_pieces,
    input  logic [TMR_W-1:0]   tmo_load,
    input  logic               hit,
    input  err_mask_t          hit_err,
    output logic               busy,
    output logic               commit,
    output err_mask_t          commit_mask
);
    localparam logic [PIECE_W-1:0] LAST_ONE = PIECE_W'(1);
    localparam err_mask_t          TO_MASK  = err_mask_t'(1) << EB_TO;

    entry_state_e       state_q, state_d;
    logic [PIECE_W-1:0] cnt_q, cnt_d;
    logic [TMR_W-1:0]   tmr_q, tmr_d;
    err_mask_t          acc_q, acc_d;
    logic               last_piece, expire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ES_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tmr_q <= '0;
            acc_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            tmr_q <= tmr_d;
            acc_q <= acc_d;
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q == ES_PENDING);
        last_piece  = busy && hit && (cnt_q == LAST_ONE);
        expire      = busy && !hit && (tmr_q == '0);
        commit      = last_piece || expire;
        commit_mask = hit ? (acc_q | hit_err) : (acc_q | TO_MASK);
    end

    // next state: ISSUE, PIECE, LAST_PIECE, EXPIRE
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tmr_d   = tmr_q;
        acc_d   = acc_q;
        unique case (state_q)
            ES_FREE: begin
                if (issue) begin
                    state_d = ES_PENDING;
                    cnt_d   = issue_pieces;
                    tmr_d   = tmo_load;
                    acc_d   = '0;
                end
            end
            ES_PENDING: begin
                if (last_piece || expire) begin
                    state_d = ES_FREE;
                end else if (hit) begin
                    acc_d = acc_q | hit_err;
                    cnt_d = cnt_q - LAST_ONE;
                    tmr_d = tmo_load;
                end else begin
                    tmr_d = tmr_q - TMR_W'(1);
                end
            end
        endcase
    end

    p_pending_has_pieces_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0));
    p_commit_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
    p_hold_until_resolved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> busy);
    p_expiry_logs_timeout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hit && commit) |-> commit_mask[EB_TO]);
endmodule

// File: rtl/npt_status.sv
module npt_status
    import npt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  err_mask_t        commit_err,
    input  logic             unexpected,
    input  logic [UNC_W-1:0] unc_clr,
    input  logic [DET_W-1:0] det_clr,
    input  logic [UNC_W-1:0] unc_en,
    input  logic [DET_W-1:0] det_en,
    output logic [UNC_W-1:0] unc_status,
    output logic [DET_W-1:0] det_status,
    output logic             irq
);
    logic [UNC_W-1:0] unc_set;
    logic [DET_W-1:0] det_set;

    always_comb begin
        unc_set            = '0;
        det_set            = '0;
        unc_set[UNC_UR]    = commit_err[EB_UR];
        unc_set[UNC_CA]    = commit_err[EB_CA];
        unc_set[UNC_EP]    = commit_err[EB_EP];
        unc_set[UNC_ECRC]  = commit_err[EB_ECRC];
        unc_set[UNC_UNEXP] = unexpected;
        det_set[DET_TO]    = commit_err[EB_TO];
        det_set[DET_NS]    = commit_err[EB_UR] | commit_err[EB_CA];
        det_set[DET_CA]    = commit_err[EB_CA];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unc_status <= '0;
            det_status <= '0;
        end else begin
            unc_status <= (unc_status & ~unc_clr) | unc_set;
            det_status <= (det_status & ~det_clr) | det_set;
        end
    end

    assign irq = (|(unc_status & unc_en)) | (|(det_status & det_en));

    p_unc_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((unc_status & $past(unc_status & ~unc_clr)) == $past(unc_status & ~unc_clr)));
    p_det_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((det_status & $past(det_status & ~det_clr)) == $past(det_status & ~det_clr)));
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((unc_en == '0) && (det_en == '0)) |-> !irq);
endmodule

// File: rtl/npt_tracker.sv
module npt_tracker
    import npt_pkg::*;
#(
    parameter int NUM_TAGS = 8,
    parameter int PIECE_W  = 4,
    parameter int TMR_W    = 16,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [TAG_W-1:0]    req_tag,
    input  logic [PIECE_W-1:0]  req_pieces,
    input  logic                cpl_valid,
    input  logic [TAG_W-1:0]    cpl_tag,
    input  logic [1:0]          cpl_status,
    input  logic                cpl_poisoned,
    input  logic                cpl_ecrc_err,
    input  logic [TMR_W-1:0]    cfg_timeout,
    input  logic [UNC_W-1:0]    unc_en,
    input  logic [DET_W-1:0]    det_en,
    input  logic [UNC_W-1:0]    unc_clr,
    input  logic [DET_W-1:0]    det_clr,
    output logic [UNC_W-1:0]    unc_status,
    output logic [DET_W-1:0]    det_status,
    output logic [NUM_TAGS-1:0] tag_busy,
    output logic                irq
);
    err_mask_t               cpl_err;
    err_mask_t               commit_any;
    err_mask_t               commit_mask [NUM_TAGS];
    logic [NUM_TAGS-1:0]     commit_vec;
    logic                    unexpected;

    npt_classify u_classify (
        .status   (cpl_status),
        .poisoned (cpl_poisoned),
        .ecrc_err (cpl_ecrc_err),
        .err      (cpl_err)
    );

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_entry
        npt_entry #(
            .PIECE_W (PIECE_W),
            .TMR_W   (TMR_W)
        ) u_entry (
            .clk          (clk),
            .rst_n        (rst_n),
            .issue        (req_valid && (req_tag == TAG_W'(g)) && (req_pieces != '0)),
            .issue_pieces (req_pieces),
            .tmo_load     (cfg_timeout),
            .hit          (cpl_valid && (cpl_tag == TAG_W'(g))),
            .hit_err      (cpl_err),
            .busy         (tag_busy[g]),
            .commit       (commit_vec[g]),
            .commit_mask  (commit_mask[g])
        );
    end

    always_comb begin
        commit_any = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (commit_vec[i]) commit_any = commit_any | commit_mask[i];
        end
    end

    assign unexpected = cpl_valid && !tag_busy[cpl_tag];

    npt_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_err (commit_any),
        .unexpected (unexpected),
        .unc_clr    (unc_clr),
        .det_clr    (det_clr),
        .unc_en     (unc_en),
        .det_en     (det_en),
        .unc_status (unc_status),
        .det_status (det_status),
        .irq        (irq)
    );

    p_unexpected_logged_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !tag_busy[cpl_tag]) |=> unc_status[UNC_UNEXP]);
    p_issue_accepted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_pieces != '0) && !tag_busy[req_tag]) |=> tag_busy[$past(req_tag)]);
endmodule

// File: tb/npt_tracker_bench.sv
module npt_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_tag;
    logic [3:0]  req_pieces;
    logic        cpl_valid;
    logic [2:0]  cpl_tag;
    logic [1:0]  cpl_status;
    logic        cpl_poisoned;
    logic        cpl_ecrc_err;
    logic [15:0] cfg_timeout;
    logic [31:0] unc_en, unc_clr;
    logic [2:0]  det_en, det_clr;
    logic [31:0] unc_status;
    logic [2:0]  det_status;
    logic [7:0]  tag_busy;
    logic        irq;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    npt_tracker u_npt_tracker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_tag(req_tag), .req_pieces(req_pieces),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
        .cpl_poisoned(cpl_poisoned), .cpl_ecrc_err(cpl_ecrc_err),
        .cfg_timeout(cfg_timeout), .unc_en(unc_en), .det_en(det_en),
        .unc_clr(unc_clr), .det_clr(det_clr),
        .unc_status(unc_status), .det_status(det_status),
        .tag_busy(tag_busy), .irq(irq)
    );

    // behavioural reference model
    bit        m_live [8];
    int        m_rem  [8];
    int        m_tmr  [8];
    bit [4:0]  m_acc  [8];
    bit [31:0] m_unc = '0;
    bit [2:0]  m_det = '0;

    always @(posedge clk) begin : model
        bit [31:0] uset;
        bit [2:0]  dset;
        bit [4:0]  e;
        bit [4:0]  fin;
        if (!rst_n) begin
            for (int t = 0; t < 8; t++) begin
                m_live[t] = 1'b0; m_rem[t] = 0; m_tmr[t] = 0; m_acc[t] = '0;
            end
            m_unc = '0;
            m_det = '0;
        end else begin
            uset = '0; dset = '0; fin = '0; e = '0;
            if (cpl_status == 2'd1 || cpl_status == 2'd3) e[0] = 1'b1;
            if (cpl_status == 2'd2) e[1] = 1'b1;
            e[2] = cpl_poisoned;
            e[3] = cpl_ecrc_err;
            if (cpl_valid && !m_live[cpl_tag]) uset[16] = 1'b1;
            for (int t = 0; t < 8; t++) begin
                if (m_live[t]) begin
                    if (cpl_valid && cpl_tag == 3'(t)) begin
                        m_acc[t] = m_acc[t] | e;
                        if (m_rem[t] == 1) begin
                            fin = fin | m_acc[t];
                            m_live[t] = 1'b0;
                        end else begin
                            m_rem[t] = m_rem[t] - 1;
                            m_tmr[t] = int'(cfg_timeout);
                        end
                    end else if (m_tmr[t] == 0) begin
                        fin = fin | m_acc[t] | 5'b10000;
                        m_live[t] = 1'b0;
                    end else begin
                        m_tmr[t] = m_tmr[t] - 1;
                    end
                end else if (req_valid && req_tag == 3'(t) && req_pieces != 0) begin
                    m_live[t] = 1'b1;
                    m_rem[t]  = int'(req_pieces);
                    m_tmr[t]  = int'(cfg_timeout);
                    m_acc[t]  = '0;
                end
            end
            if (fin[0]) begin uset[20] = 1'b1; dset[1] = 1'b1; end
            if (fin[1]) begin uset[15] = 1'b1; dset[1] = 1'b1; dset[2] = 1'b1; end
            if (fin[2]) uset[12] = 1'b1;
            if (fin[3]) uset[19] = 1'b1;
            if (fin[4]) dset[0] = 1'b1;
            m_unc = (m_unc & ~unc_clr) | uset;
            m_det = (m_det & ~det_clr) | dset;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", what, $time, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin : compare
        bit [7:0] busy_exp;
        bit       irq_exp;
        if (!done) begin
            for (int t = 0; t < 8; t++) busy_exp[t] = m_live[t];
            irq_exp = (|(m_unc & unc_en)) || (|(m_det & det_en));
            check(unc_status, m_unc, "R2 R3 R4 R5 R6 R7 R10 unc_status");
            check(32'(det_status), 32'(m_det), "R1 R3 R4 R7 R10 det_status");
            check(32'(tag_busy), 32'(busy_exp), "R1 R8 tag_busy");
            check(32'(irq), 32'(irq_exp), "R9 irq");
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic issue(input int t, input int p);
        req_valid = 1'b1; req_tag = 3'(t); req_pieces = 4'(p);
        tick();
        req_valid = 1'b0;
    endtask

    task automatic cpl(input int t, input int st, input bit ep, input bit ec);
        cpl_valid = 1'b1; cpl_tag = 3'(t); cpl_status = 2'(st);
        cpl_poisoned = ep; cpl_ecrc_err = ec;
        tick();
        cpl_valid = 1'b0; cpl_poisoned = 1'b0; cpl_ecrc_err = 1'b0; cpl_status = 2'd0;
    endtask

    task automatic clear_all();
        unc_clr = '1; det_clr = '1;
        tick();
        unc_clr = '0; det_clr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        finish_run();
    end

    initial begin : stimulus
        rst_n = 1'b0;
        req_valid = 1'b0; req_tag = '0; req_pieces = '0;
        cpl_valid = 1'b0; cpl_tag = '0; cpl_status = '0;
        cpl_poisoned = 1'b0; cpl_ecrc_err = 1'b0;
        cfg_timeout = 16'd5;
        unc_en = '0; det_en = '0; unc_clr = '0; det_clr = '0;
        repeat (3) tick();   // reset state is compared here
        rst_n = 1'b1;
        tick();

        // R8, R3: single piece, unsupported request (code 1)
        issue(0, 1); tick(); cpl(0, 1, 0, 0); repeat (2) tick();
        // R4: completer abort (code 2)
        issue(1, 1); cpl(1, 2, 0, 0); repeat (2) tick();
        clear_all();
        // R5, R7: three pieces, first poisoned, bit held until the last
        issue(2, 3); cpl(2, 0, 1, 0); tick(); cpl(2, 0, 0, 0); tick(); cpl(2, 0, 0, 0); tick();
        // R6: ECRC error, R3 reserved code 3
        issue(3, 1); cpl(3, 0, 0, 1); tick();
        issue(3, 1); cpl(3, 3, 0, 0); tick();
        clear_all();
        // R1, R2: expiry, then a late completion is unexpected
        issue(4, 1); repeat (10) tick(); cpl(4, 0, 0, 0); repeat (2) tick();
        // R8: issue to busy tag ignored, zero pieces ignored
        issue(5, 2); issue(5, 1); cpl(5, 0, 0, 0); tick(); cpl(5, 0, 0, 0); tick();
        issue(6, 0); repeat (2) tick();
        // R9: enables gate the interrupt
        unc_en = 32'h0001_0000; tick(); unc_en = '0; det_en = 3'b001; tick();
        det_en = '0; tick();
        // R10: set and clear of the same bit in one cycle
        unc_clr = 32'h0001_0000; cpl(6, 0, 0, 0); unc_clr = '0; repeat (2) tick();
        clear_all();
        // R7, R1: split group with an error, remaining piece expires
        issue(7, 2); cpl(7, 1, 0, 0); repeat (9) tick();
        // R11-free random phase: overlaps of all traffic
        for (int c = 0; c < 4000; c++) begin
            req_valid    = ($urandom_range(0, 3) == 0);
            req_tag      = 3'($urandom_range(0, 7));
            req_pieces   = 4'($urandom_range(0, 3));
            cpl_valid    = ($urandom_range(0, 2) == 0);
            cpl_tag      = 3'($urandom_range(0, 7));
            cpl_status   = 2'($urandom_range(0, 3));
            cpl_poisoned = ($urandom_range(0, 7) == 0);
            cpl_ecrc_err = ($urandom_range(0, 7) == 0);
            unc_clr      = ($urandom_range(0, 15) == 0) ? 32'($urandom()) : '0;
            det_clr      = ($urandom_range(0, 15) == 0) ? 3'($urandom_range(0, 7)) : '0;
            if ($urandom_range(0, 31) == 0) unc_en = 32'($urandom()) & 32'h0019_9000;
            if ($urandom_range(0, 31) == 0) det_en = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 63) == 0) cfg_timeout = 16'($urandom_range(0, 12));
            tick();
        end
        req_valid = 1'b0; cpl_valid = 1'b0; unc_clr = '0; det_clr = '0;
        repeat (20) tick();
        finish_run();
    end
endmodule